// File: doc/BRIEF.md
# Flow-Through Burst SRAM Model

This block is a synthesizable behavioural model of a synchronous static memory. Its read path is flow-through: no output register stands between the array and the data output. An address is captured on a rising clock edge, and the word it selects appears on the output during the cycle that follows that edge. The two low address bits come from a two-bit burst counter. The counter runs in either linear or interleaved order, so a host can stream four words after supplying a single address.

Two address strobes can start an access. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, as the write enables decide. Three chip enables gate address capture. Writes cover either the whole word or any chosen subset of its four bytes. An asynchronous output enable and a snooze input control the output. When the output is idle it drives zeros and clears a valid flag, which takes the place of a high-impedance bus. The number of words actually stored is a parameter. Address bits above that depth alias onto the stored words.

Top module: `fts_sram`

## Requirements
- R1: After synchronous reset the device is deselected: `dout` is zero and `dout_vld` is low until an address is captured.
- R2: An address is captured on a rising edge only when `ce0`=1, `ce1_n`=0, `ce2`=1 and at least one of `adsp_n`/`adsc_n` is low. The word at that address then appears on `dout` in the cycle that follows.
- R3: If a strobe is low while any chip enable is inactive, the device becomes deselected (`dout`=0, `dout_vld`=0). Later advance or hold cycles write nothing until the next capture.
- R4: Each capture loads the burst counter with 0. A rising edge with both strobes high and `adv_n` low increments the counter, which wraps modulo 4.
- R5: With `burst_lin`=1 the low two address bits equal (start low bits + counter) mod 4. For a start of 2 the sequence is 2,3,0,1.
- R6: With `burst_lin`=0 the low two address bits equal start low bits XOR counter. For a start of 1 the sequence is 1,0,3,2.
- R7: A rising edge with both strobes and `adv_n` high leaves the registered address unchanged, which suspends the burst.
- R8: `gwe_n`=0 writes all four bytes. Otherwise `bwe_n`=0 writes byte i (bits 8i+7..8i) wherever `bw_n[i]`=0. Any other combination writes nothing. A write takes effect on the edge that selects the address.
- R9: A capture by `adsp_n`=0 (chip selected) is always a read. Its write enables are ignored.
- R10: Read data is flow-through. After each edge `dout` shows the current content of the registered address, including data written on that same edge.
- R11: `oe_n`=1 forces `dout` to zero and `dout_vld` low at once, without waiting for a clock edge.
- R12: While `sleep`=1 the device captures no address, does not advance, writes nothing and keeps its output idle. On release it continues at the address it held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address presented with a strobe |
| adsp_n | input | 1 | Processor-side address strobe, active low (read start) |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce0 | input | 1 | Chip enable, active high |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| gwe_n | input | 1 | Whole-word write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 4 | Per-byte write strobes, active low, bit i selects byte i |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Snooze request, active high |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, zero when idle |
| dout_vld | output | 1 | High when dout carries array data |

## Verification
The bench builds the block with `MEM_AW`=6, so 64 words are stored and the full 20-bit address aliases onto them. With that depth a random address stream returns to the same word often enough that partial byte writes, reads after writes and bursts over freshly written data all occur in quantity. The bench fills all 64 words first, so every read it compares has a known value. Directed sequences cover the wrap of both burst orders from non-zero starting offsets. Random traffic mixes deselect, snooze and output-enable pulses into bursts that are in progress.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    // what a rising edge does to the access state
    typedef enum logic [2:0] {
        CYC_HOLD,
        CYC_ADV,
        CYC_LOAD_RD,
        CYC_LOAD_WR,
        CYC_DESEL,
        CYC_SLEEP
    } cyc_e;

    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       lin);
        return lin ? (start + cnt) : (start ^ cnt);
    endfunction

    function automatic lane_mask_t lane_mask(input logic       gwe_n,
                                             input logic       bwe_n,
                                             input lane_mask_t bw_n);
        if (!gwe_n)      return '1;
        else if (!bwe_n) return ~bw_n;
        else             return '0;
    endfunction

    function automatic cyc_e classify(input logic sleep,
                                      input logic sel,
                                      input logic adsp_n,
                                      input logic adsc_n,
                                      input logic adv_n);
        if (sleep)                       return CYC_SLEEP;
        else if (!adsp_n || !adsc_n) begin
            if (!sel)                    return CYC_DESEL;
            else if (!adsp_n)            return CYC_LOAD_RD;
            else                         return CYC_LOAD_WR;
        end
        else if (!adv_n)                 return CYC_ADV;
        else                             return CYC_HOLD;
    endfunction

endpackage

// File: rtl/fts_addr_ctrl.sv
module fts_addr_ctrl
    import fts_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_e              kind,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              burst_lin,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              active,
    output logic              nxt_active
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              act;
    } acc_state_t;

    acc_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (kind)
            CYC_LOAD_RD, CYC_LOAD_WR: begin
                st_d.base = addr_in;
                st_d.cnt  = 2'd0;
                st_d.act  = 1'b1;
            end
            CYC_DESEL: st_d.act = 1'b0;
            CYC_ADV:   st_d.cnt = st_q.cnt + 2'd1;
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cur_addr   = {st_q.base[ADDR_W-1:2], burst_low(st_q.base[1:0], st_q.cnt, burst_lin)};
    assign nxt_addr   = {st_d.base[ADDR_W-1:2], burst_low(st_d.base[1:0], st_d.cnt, burst_lin)};
    assign active     = st_q.act;
    assign nxt_active = st_d.act;

endmodule

// File: rtl/fts_wr_ctrl.sv
module fts_wr_ctrl
    import fts_pkg::*;
(
    input  cyc_e       kind,
    input  logic       nxt_active,
    input  logic       gwe_n,
    input  logic       bwe_n,
    input  lane_mask_t bw_n,
    output lane_mask_t we
);

    logic wr_cycle;

    // processor-strobe loads, deselects and snooze never write
    assign wr_cycle = (kind == CYC_LOAD_WR) || (kind == CYC_ADV) || (kind == CYC_HOLD);
    assign we       = (wr_cycle && nxt_active) ? lane_mask(gwe_n, bwe_n, bw_n) : '0;

endmodule

// File: rtl/fts_mem_array.sv
module fts_mem_array
    import fts_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  lane_mask_t        we,
    input  logic [MEM_AW-1:0] waddr,
    input  word_t             wdata,
    input  logic [MEM_AW-1:0] raddr,
    output word_t             rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce0,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              gwe_n,
    input  logic              bwe_n,
    input  logic [3:0]        bw_n,
    input  logic              burst_lin,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [31:0]       din,
    output logic [31:0]       dout,
    output logic              dout_vld
);

    logic              sel;
    cyc_e              kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic              active;
    logic              nxt_active;
    lane_mask_t        we;
    word_t             rdata;
    logic              out_en;
    logic              unused_hi_bits;

    assign sel  = ce0 && !ce1_n && ce2;
    assign kind = classify(sleep, sel, adsp_n, adsc_n, adv_n);

    fts_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .addr_in    (addr),
        .burst_lin  (burst_lin),
        .cur_addr   (cur_addr),
        .nxt_addr   (nxt_addr),
        .active     (active),
        .nxt_active (nxt_active)
    );

    fts_wr_ctrl u_wr (
        .kind       (kind),
        .nxt_active (nxt_active),
        .gwe_n      (gwe_n),
        .bwe_n      (bwe_n),
        .bw_n       (bw_n),
        .we         (we)
    );

    fts_mem_array #(.MEM_AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (nxt_addr[MEM_AW-1:0]),
        .wdata (din),
        .raddr (cur_addr[MEM_AW-1:0]),
        .rdata (rdata)
    );

    // address bits above the stored depth alias onto it
    assign unused_hi_bits = ^{cur_addr[ADDR_W-1:MEM_AW], nxt_addr[ADDR_W-1:MEM_AW]};

    // output enable and snooze act without a clock
    assign out_en   = active && !oe_n && !sleep;
    assign dout     = out_en ? rdata : '0;
    assign dout_vld = out_en;

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              adv_n,
    input logic              ce0,
    input logic              ce1_n,
    input logic              ce2,
    input logic              burst_lin,
    input logic              oe_n,
    input logic              sleep,
    input logic [31:0]       dout,
    input logic              dout_vld,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              active
);

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (dout == 32'd0 && !dout_vld)); // R11

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!sleep && ce0 && !ce1_n && ce2 && (!adsp_n || !adsc_n))
        |=> (cur_addr == $past(addr))); // R2

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !(ce0 && !ce1_n && ce2) && (!adsp_n || !adsc_n))
        |=> !dout_vld); // R3

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adsp_n && adsc_n && adv_n)
        |=> (cur_addr == $past(cur_addr) || burst_lin != $past(burst_lin))); // R7

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adsp_n && adsc_n && !adv_n && burst_lin)
        |=> (!burst_lin || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)); // R5

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(active) &&
                   (cur_addr == $past(cur_addr) || burst_lin != $past(burst_lin)))); // R12

    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dout_vld); // R12

endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .adsp_n    (adsp_n),
    .adsc_n    (adsc_n),
    .adv_n     (adv_n),
    .ce0       (ce0),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .burst_lin (burst_lin),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .dout      (dout),
    .dout_vld  (dout_vld),
    .cur_addr  (cur_addr),
    .active    (active)
);

// File: tb/fts_sram_test.sv
module fts_sram_test;

    localparam int AW  = 20;
    localparam int MAW = 6;
    localparam int NW  = 1 << MAW;

    logic          clk;
    logic          rst;
    logic [AW-1:0] addr;
    logic          adsp_n, adsc_n, adv_n;
    logic          ce0, ce1_n, ce2;
    logic          gwe_n, bwe_n;
    logic [3:0]    bw_n;
    logic          burst_lin, oe_n, sleep;
    logic [31:0]   din;
    logic [31:0]   dout;
    logic          dout_vld;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic          m_act;
    logic [31:0]   mem_m [NW];

    fts_sram #(.ADDR_W(AW), .MEM_AW(MAW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce0(ce0), .ce1_n(ce1_n), .ce2(ce2), .gwe_n(gwe_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .burst_lin(burst_lin), .oe_n(oe_n),
        .sleep(sleep), .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] c, input logic lin);
        return lin ? s + c : s ^ c;
    endfunction

    function automatic logic [MAW-1:0] exp_idx();
        return {m_base[MAW-1:2], exp_low(m_base[1:0], m_cnt, burst_lin)};
    endfunction

    function automatic logic [3:0] exp_mask();
        if (!gwe_n) return 4'hF;
        if (!bwe_n) return ~bw_n;
        return 4'h0;
    endfunction

    task automatic model_step();
        logic sel;
        logic wr;
        logic [3:0] mk;
        sel = ce0 && !ce1_n && ce2;
        wr  = 1'b0;
        if (sleep) begin
            wr = 1'b0;
        end else if (!adsp_n || !adsc_n) begin
            if (sel) begin
                m_base = addr; m_cnt = 2'd0; m_act = 1'b1;
                wr = adsp_n;
            end else begin
                m_act = 1'b0;
            end
        end else if (!adv_n) begin
            m_cnt = m_cnt + 2'd1;
            wr = m_act;
        end else begin
            wr = m_act;
        end
        if (wr) begin
            mk = exp_mask();
            for (int i = 0; i < 4; i++)
                if (mk[i]) mem_m[exp_idx()][i*8 +: 8] = din[i*8 +: 8];
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] gd, input logic gv,
                       input logic [31:0] ed, input logic ev);
        n_chk++;
        if (gd !== ed || gv !== ev) begin
            n_bad++;
            $display("FAIL %s: dout=%h vld=%b expected dout=%h vld=%b", tag, gd, gv, ed, ev);
        end
    endtask

    task automatic chk_model(input string tag);
        logic ev;
        ev = m_act && !oe_n && !sleep;
        chk(tag, dout, dout_vld, ev ? mem_m[exp_idx()] : 32'd0, ev);
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        #1;
        chk_model(tag);
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1;
        ce0 = 1; ce1_n = 0; ce2 = 1;
        gwe_n = 1; bwe_n = 1; bw_n = 4'hF;
        oe_n = 0; sleep = 0;
    endtask

    task automatic ctrl_write(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        idle(); addr = a; adsc_n = 0; gwe_n = 0; din = d;
        cyc(tag);
    endtask

    task automatic proc_read(input logic [AW-1:0] a, input logic lin, input string tag);
        idle(); addr = a; adsp_n = 0; burst_lin = lin;
        cyc(tag);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        rst = 1; addr = '0; din = '0; burst_lin = 1;
        idle();
        m_base = '0; m_cnt = '0; m_act = 1'b0;
        for (int i = 0; i < NW; i++) mem_m[i] = 32'd0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk("R1", dout, dout_vld, 32'd0, 1'b0);
        cyc("R1");

        // fill every word so later reads are defined
        for (int i = 0; i < NW; i++)
            ctrl_write(AW'(i) | 20'hA0000, 32'hC0DE_0000 | i, "R8");

        // whole word write then flow-through read
        ctrl_write(20'h00010, 32'hA5A5_0001, "R8");
        chk("R10", dout, dout_vld, 32'hA5A5_0001, 1'b1);
        // byte a and c only
        idle(); addr = 20'h00010; adsc_n = 0; bwe_n = 0; bw_n = 4'b1010; din = 32'h1122_3344;
        cyc("R8");
        chk("R8", dout, dout_vld, 32'hA522_0044, 1'b1);
        // neither enable: no write
        idle(); addr = 20'h00010; adsc_n = 0; din = 32'h0;
        cyc("R8");
        chk("R8", dout, dout_vld, 32'hA522_0044, 1'b1);
        // processor strobe ignores the write enables
        idle(); addr = 20'h00010; adsp_n = 0; gwe_n = 0; din = 32'hFFFF_FFFF;
        cyc("R9");
        chk("R9", dout, dout_vld, 32'hA522_0044, 1'b1);
        idle(); cyc("R9");
        chk("R9", dout, dout_vld, 32'hA522_0044, 1'b1);

        // burst block at 0x20..0x23
        for (int i = 0; i < 4; i++) ctrl_write(20'h00020 + i, 32'hB0 + i, "R8");
        proc_read(20'h00022, 1'b1, "R2");
        chk("R5", dout, dout_vld, 32'hB2, 1'b1);
        for (int k = 1; k <= 5; k++) begin
            idle(); adv_n = 0; cyc("R4");
            chk("R5", dout, dout_vld, 32'hB0 + ((2 + k) % 4), 1'b1);
        end
        proc_read(20'h00021, 1'b0, "R2");
        chk("R6", dout, dout_vld, 32'hB1, 1'b1);
        for (int k = 1; k <= 4; k++) begin
            idle(); adv_n = 0; cyc("R6");
            chk("R6", dout, dout_vld, 32'hB0 + (1 ^ (k % 4)), 1'b1);
        end
        // suspend: low bits now 1^0 = 1
        idle(); cyc("R7"); cyc("R7");
        chk("R7", dout, dout_vld, 32'hB1, 1'b1);

        // write in the burst via advance after a processor start
        burst_lin = 1'b1;
        proc_read(20'h00020, 1'b1, "R9");
        idle(); adv_n = 0; gwe_n = 0; din = 32'hD00D_0021; cyc("R8");
        chk("R8", dout, dout_vld, 32'hD00D_0021, 1'b1);

        // deselect, then advance with write while deselected
        idle(); addr = 20'h00023; adsc_n = 0; ce1_n = 1; gwe_n = 0; din = 32'h0BAD;
        cyc("R3");
        chk("R3", dout, dout_vld, 32'd0, 1'b0);
        idle(); ce0 = 0; adsc_n = 0; cyc("R3");
        idle(); adv_n = 0; gwe_n = 0; din = 32'h0BAD; cyc("R3");
        chk("R3", dout, dout_vld, 32'd0, 1'b0);
        proc_read(20'h00023, 1'b1, "R3");
        chk("R3", dout, dout_vld, 32'hB3, 1'b1);

        // asynchronous output enable
        #2 oe_n = 1; #1;
        chk("R11", dout, dout_vld, 32'd0, 1'b0);
        oe_n = 0; #1;
        chk("R11", dout, dout_vld, 32'hB3, 1'b1);

        // snooze blocks capture and write
        idle(); sleep = 1; addr = 20'h00020; adsc_n = 0; gwe_n = 0; din = 32'h0;
        cyc("R12");
        chk("R12", dout, dout_vld, 32'd0, 1'b0);
        idle(); cyc("R12");
        chk("R12", dout, dout_vld, 32'hB3, 1'b1);
        proc_read(20'h00021, 1'b1, "R12");
        chk("R12", dout, dout_vld, 32'hD00D_0021, 1'b1);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic strobe;
            idle();
            addr   = AW'($urandom) & 20'hFFF3F | 20'h0;
            adsp_n = ($urandom % 8) != 0;
            adsc_n = ($urandom % 6) != 0;
            adv_n  = ($urandom % 2) != 0;
            ce0    = ($urandom % 12) != 0;
            ce1_n  = ($urandom % 12) == 0;
            ce2    = ($urandom % 12) != 0;
            gwe_n  = ($urandom % 4) != 0;
            bwe_n  = ($urandom % 2) != 0;
            bw_n   = 4'($urandom);
            din    = $urandom;
            sleep  = ($urandom % 16) == 0;
            oe_n   = ($urandom % 8) == 0;
            strobe = !adsp_n || !adsc_n;
            if (strobe && !sleep) burst_lin = 1'($urandom);
            cyc("R10");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule